// File: doc/BRIEF.md
# Serial Management Interface Master

This block lets a host run single clause-22 management transactions against an external PHY over a two-wire clock and data bus. The host programs a configuration register (bus enable and MDC divider) and a write-data register. It then writes a control word carrying the PHY address, the register address, an opcode and an initiate flag. The block generates MDC, shifts the complete frame out on the data line, releases the line for the turnaround and data phases of a read, and collects the 16 returned bits into a read-data register. While a frame is on the wire the ready flag in the control register reads as zero.

The frame sequencer holds eight named states. IDLE goes to PREAMBLE on an accepted launch. PREAMBLE (32 ones) goes to SOF (01), then OPCODE (01 for write, 10 for read), then PHYAD (5 bits), then REGAD (5 bits), then TURN (two bit times), then DATA (16 bits), and finally back to IDLE. Each transition happens on the falling MDC edge that ends the last bit of the state. The host-visible registers are selected by a 2-bit index: 0 = configuration, 1 = control, 2 = write data, 3 = read data.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The configuration register (index 0) keeps only bits 6:0 of a write: bit 6 is the bus enable and bits 5:0 are the MDC divider. Bits 31:7 read back as zero.
- R2: A write to the control register (index 1) with bit 11 set launches a frame only when the enable bit is set and the block is idle. A control write with bit 11 clear, or with the enable clear, leaves MDC low and ready high.
- R3: Opcode 1 (control bits 15:14 = 01) produces a write frame, sent MSB first: 32 ones, 01, 01, the PHY address from bits 28:24, the register address from bits 20:16, turnaround 10, then the 16-bit write-data register. The master drives every bit of this frame.
- R4: Opcode 2 (bits 15:14 = 10) produces a read frame with opcode 10. The master releases the line (output enable low) for the two turnaround bits and the 16 data bits. It samples the line at each rising MDC edge of the data phase and places the bits, MSB first, into the read-data register (index 3).
- R5: Opcodes 0 and 3 with initiate set are ignored: no MDC edges occur, ready stays 1, and the read-data register is unchanged.
- R6: Bit 7 of a control-register read is the ready flag: 1 after reset and when idle, 0 from the cycle after a launch until the frame ends.
- R7: A control write with initiate set while a frame is in progress is ignored and produces no additional frame.
- R8: Each MDC half period lasts as many system clocks as the divider value, and a divider of zero counts as one. MDC is low whenever no frame is in progress.
- R9: A read from a PHY address where nothing drives the line (the line idles high) returns 0xFFFF.
- R10: The states run in the order PREAMBLE, SOF, OPCODE, PHYAD, REGAD, TURN, DATA, and return to IDLE. In IDLE the output enable is low.
- R11: The data line and its output enable change only together with a falling MDC edge, never at a rising one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_sel | input | 2 | Register index for writes |
| host_wr_data | input | 32 | Register write value |
| host_rd_sel | input | 2 | Register index for reads |
| host_rd_data | output | 32 | Selected register value (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value seen at the pad |

## Verification
The assertions check four things on every cycle. The states follow their fixed order. The line is released during the turnaround and data phases of a read and whenever the block is idle. Data and output enable never move on a rising MDC edge. MDC stays low while no frame is in progress, and an accepted launch is followed by busy. The exact bit contents of write and read frames, the read value, the value returned from an empty address, the MDC period for a zero and a non-zero divider, and the rejection of bad opcodes, disabled launches and launches while busy are visible only through the bench's scenarios. In those scenarios a scoreboard decodes each frame from the pins and a small PHY model answers reads.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_SOF,
        S_OPCODE,
        S_PHYAD,
        S_REGAD,
        S_TURN,
        S_DATA
    } mdio_state_e;

    // host register indices
    localparam logic [1:0] SEL_CFG   = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_WDATA = 2'd2;
    localparam logic [1:0] SEL_RDATA = 2'd3;

    // control word field positions
    localparam int CTRL_PHY_LSB = 24;
    localparam int CTRL_REG_LSB = 16;
    localparam int CTRL_OP_LSB  = 14;
    localparam int CTRL_GO_BIT  = 11;
    localparam int CTRL_RDY_BIT = 7;

    // configuration field positions
    localparam int CFG_EN_BIT   = 6;
    localparam int CFG_KEEP_W   = 7;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    function automatic mdio_state_e state_after(input mdio_state_e s);
        mdio_state_e n;
        unique case (s)
            S_IDLE:     n = S_PREAMBLE;
            S_PREAMBLE: n = S_SOF;
            S_SOF:      n = S_OPCODE;
            S_OPCODE:   n = S_PHYAD;
            S_PHYAD:    n = S_REGAD;
            S_REGAD:    n = S_TURN;
            S_TURN:     n = S_DATA;
            S_DATA:     n = S_IDLE;
            default:    n = S_IDLE;
        endcase
        return n;
    endfunction

    function automatic int state_len(input mdio_state_e s, input int pre_bits,
                                     input int addr_w, input int data_w);
        int n;
        unique case (s)
            S_IDLE:     n = 1;
            S_PREAMBLE: n = pre_bits;
            S_SOF:      n = 2;
            S_OPCODE:   n = 2;
            S_PHYAD:    n = addr_w;
            S_REGAD:    n = addr_w;
            S_TURN:     n = 2;
            S_DATA:     n = data_w;
            default:    n = 1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_m1;
    logic             wrap;

    // zero divider behaves as divide-by-one
    assign half_m1  = (div == '0) ? '0 : div - 1'b1;
    assign wrap     = run && (cnt_q == half_m1);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_rd,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_value
);
    localparam int FRAME_W = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int CNT_W   = $clog2(PRE_BITS + DATA_W + 1);

    mdio_state_e        st_q, st_nx;
    logic [CNT_W-1:0]   bcnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] frame;
    logic [DATA_W-1:0]  rsh_q;
    logic               rd_q;
    logic               last_bit;
    logic               done_q;

    assign frame = {{PRE_BITS{1'b1}}, 2'b01,
                    (op_rd ? OPC_READ : OPC_WRITE),
                    phy_addr, reg_addr,
                    (op_rd ? 2'b11 : 2'b10),
                    (op_rd ? {DATA_W{1'b1}} : wdata)};

    assign last_bit = (int'(bcnt_q) == state_len(st_q, PRE_BITS, ADDR_W, DATA_W) - 1);

    // next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE:     if (start) st_nx = S_PREAMBLE;
            S_PREAMBLE,
            S_SOF,
            S_OPCODE,
            S_PHYAD,
            S_REGAD,
            S_TURN,
            S_DATA:     if (fall_stb && last_bit) st_nx = state_after(st_q);
            default:    st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q  <= '0;
            sh_q    <= '0;
            rsh_q   <= '0;
            rd_q    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st_q == S_IDLE) begin
                if (start) begin
                    bcnt_q  <= '0;
                    sh_q    <= frame;
                    rd_q    <= op_rd;
                    mdio_o  <= frame[FRAME_W-1];
                    mdio_oe <= 1'b1;
                end
            end else begin
                if (rise_stb && st_q == S_DATA && rd_q)
                    rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
                if (fall_stb) begin
                    sh_q   <= sh_q << 1;
                    bcnt_q <= last_bit ? '0 : bcnt_q + 1'b1;
                    if (st_nx == S_IDLE) begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                        done_q  <= 1'b1;
                    end else begin
                        mdio_o  <= sh_q[FRAME_W-2];
                        mdio_oe <= !(rd_q && (st_nx == S_TURN || st_nx == S_DATA));
                    end
                end
            end
        end
    end

    assign busy     = (st_q != S_IDLE);
    assign rd_done  = done_q && rd_q;
    assign rd_value = rsh_q;

    // R10: states advance only to their fixed successor
    a_r10_state_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != $past(st_q)) |-> (st_q == state_after($past(st_q))));

    // R10: line not driven while idle
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |-> !mdio_oe);

    // R4: read frames release the line in turnaround and data
    a_r4_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && (st_q == S_TURN || st_q == S_DATA)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_value,
    output logic [DIV_W-1:0]  div,
    output logic              start,
    output logic              op_rd,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wdata
);
    logic [CFG_KEEP_W-1:0] cfg_q;
    logic [31:0]           ctrl_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [DATA_W-1:0]     rdata_q;
    logic [1:0]            opc;
    logic                  ctrl_wr;

    assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    assign opc      = wr_data[CTRL_OP_LSB +: 2];
    assign op_rd    = (opc == OPC_READ);
    assign phy_addr = wr_data[CTRL_PHY_LSB +: ADDR_W];
    assign reg_addr = wr_data[CTRL_REG_LSB +: ADDR_W];
    assign wdata    = wdata_q;
    assign div      = cfg_q[DIV_W-1:0];

    assign start = ctrl_wr && wr_data[CTRL_GO_BIT] && cfg_q[CFG_EN_BIT] && !busy
                   && (opc == OPC_WRITE || opc == OPC_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            ctrl_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_CFG:   cfg_q   <= wr_data[CFG_KEEP_W-1:0];
                    SEL_CTRL:  ctrl_q  <= wr_data;
                    SEL_WDATA: wdata_q <= wr_data[DATA_W-1:0];
                    SEL_RDATA: ;
                    default:   ;
                endcase
            end
            if (rd_done) rdata_q <= rd_value;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_CFG:   rd_data[CFG_KEEP_W-1:0] = cfg_q;
            SEL_CTRL: begin
                rd_data               = ctrl_q;
                rd_data[CTRL_RDY_BIT] = !busy;
            end
            SEL_WDATA: rd_data[DATA_W-1:0] = wdata_q;
            SEL_RDATA: rd_data[DATA_W-1:0] = rdata_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int DIV_W    = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_en,
    input  logic [1:0]  host_wr_sel,
    input  logic [31:0] host_wr_data,
    input  logic [1:0]  host_rd_sel,
    output logic [31:0] host_rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy;
    logic              start;
    logic              op_rd;
    logic              rd_done;
    logic              rise_stb;
    logic              fall_stb;
    logic [DIV_W-1:0]  div;
    logic [ADDR_W-1:0] phy_addr;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_value;

    mdio_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en),
        .wr_sel   (host_wr_sel),
        .wr_data  (host_wr_data),
        .rd_sel   (host_rd_sel),
        .rd_data  (host_rd_data),
        .busy     (busy),
        .rd_done  (rd_done),
        .rd_value (rd_value),
        .div      (div),
        .start    (start),
        .op_rd    (op_rd),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wdata    (wdata)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq #(.PRE_BITS(PRE_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_rd    (op_rd),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_value (rd_value)
    );

    // R11: data and enable are steady across a rising MDC edge
    a_r11_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8: no clock while idle
    a_r8_mdc_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R2: accepted launch from the host ports makes the block busy
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_sel == SEL_CTRL && host_wr_data[CTRL_GO_BIT] && !busy
         && host_rd_sel == host_rd_sel && div == div && phy_addr == phy_addr
         && start) |=> busy);
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [1:0]  host_wr_sel = 2'd0;
    logic [31:0] host_wr_data = 32'd0;
    logic [1:0]  host_rd_sel = 2'd0;
    logic [31:0] host_rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdio_mgmt_master u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
        .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    localparam logic [4:0] PHY_HERE = 5'd9;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] mask;
        logic        rd;
        logic        present;
        logic [15:0] rdv;
    } item_t;

    item_t exq[$];
    int n_chk = 0, n_fail = 0;
    int frames = 0, rises = 0, rc = 0, cyc = 0, last_rise = 0, period = 0;
    logic [63:0] obits = '0, omask = '0;
    logic        mdc_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic phy_bit(input int idx);
        if (exq.size() == 0) return 1'b1;
        if (!exq[0].rd || !exq[0].present) return 1'b1;
        if (idx == 47) return 1'b0;
        if (idx >= 48 && idx <= 63) return exq[0].rdv[63 - idx];
        return 1'b1;
    endfunction

    always @(posedge clk) cyc++;

    // monitor and PHY model
    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc && !mdc_prev) begin
                rises++;
                period = cyc - last_rise;
                last_rise = cyc;
                obits = {obits[62:0], mdio_oe ? mdio_o : 1'b0};
                omask = {omask[62:0], mdio_oe};
                rc++;
                if (rc == 64) begin
                    rc = 0;
                    frames++;
                    if (exq.size() == 0) begin
                        chk(1'b0, "R5 R7 unexpected frame", obits, 64'd0);
                    end else begin
                        item_t it;
                        it = exq.pop_front();
                        chk(omask == it.mask, "R4 R3 drive pattern", omask, it.mask);
                        chk((obits & it.mask) == (it.bits & it.mask),
                            "R3 R10 frame bits", obits & it.mask, it.bits & it.mask);
                    end
                end
            end
            if (!mdc && mdc_prev) mdio_i = phy_bit(rc);
        end
        mdc_prev = mdc;
    end

    task automatic host_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        host_rd_sel = sel;
        #1 d = host_rd_data;
    endtask

    task automatic wait_ready();
        logic [31:0] v;
        v = 32'd0;
        while (v[7] == 1'b0) host_read(2'd1, v);
    endtask

    task automatic launch(input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] wd);
        item_t it;
        host_write(2'd2, {16'd0, wd});
        it.rd      = (op == 2'b10);
        it.present = (phy == PHY_HERE);
        it.rdv     = 16'hA5C0 ^ {11'd0, rg};
        it.bits    = {32'hFFFF_FFFF, 2'b01, op, phy, rg,
                      it.rd ? 2'b00 : 2'b10, it.rd ? 16'h0 : wd};
        it.mask    = it.rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
        exq.push_back(it);
        host_write(2'd1, {3'd0, phy, 3'd0, rg, op, 2'b00, 1'b1, 11'd0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        host_read(2'd1, v); chk(v == 32'h80, "R6 reset ctrl", v, 32'h80);
        host_read(2'd0, v); chk(v == 32'h0, "R1 reset cfg", v, 0);
        host_read(2'd3, v); chk(v == 32'h0, "R4 reset rdata", v, 0);
        chk(!mdc && !mdio_oe, "R10 reset pins", {mdc, mdio_oe}, 0);

        // R2: enable clear -> launch ignored
        host_write(2'd1, {3'd0, 5'd9, 3'd0, 5'd1, 2'b01, 2'b00, 1'b1, 11'd0});
        host_read(2'd1, v); chk(v[7], "R2 disabled ready", v[7], 1);
        repeat (40) @(negedge clk);
        chk(rises == 0, "R2 disabled no mdc", rises, 0);

        host_write(2'd0, 32'hFFFF_FFC0);
        host_read(2'd0, v); chk(v == 32'h40, "R1 cfg keeps 7 bits", v, 32'h40);

        // R3/R6: write frame
        launch(2'b01, 5'd9, 5'd4, 16'h1234);
        host_read(2'd1, v); chk(!v[7], "R6 busy ready low", v[7], 0);
        wait_ready();
        chk(frames == 1, "R3 write frame seen", frames, 1);
        chk(period == 2, "R8 div zero period", period, 2);

        // R7: initiate while busy
        launch(2'b01, 5'd3, 5'd7, 16'hBEEF);
        repeat (6) @(negedge clk);
        host_write(2'd1, {3'd0, 5'd9, 3'd0, 5'd2, 2'b10, 2'b00, 1'b1, 11'd0});
        wait_ready();
        repeat (300) @(negedge clk);
        chk(frames == 2 && exq.size() == 0, "R7 busy launch ignored", frames, 2);

        // R4: read present PHY
        launch(2'b10, PHY_HERE, 5'd5, 16'h0);
        wait_ready();
        host_read(2'd3, v); chk(v == 32'hA5C5, "R4 read value", v, 32'hA5C5);

        // R9: read absent PHY
        launch(2'b10, 5'd2, 5'd1, 16'h0);
        wait_ready();
        host_read(2'd3, v); chk(v == 32'hFFFF, "R9 absent reads ones", v, 32'hFFFF);

        // R5: invalid opcodes
        r0 = rises;
        host_write(2'd1, {3'd0, 5'd9, 3'd0, 5'd1, 2'b00, 2'b00, 1'b1, 11'd0});
        host_read(2'd1, v); chk(v[7], "R5 op0 ready", v[7], 1);
        host_write(2'd1, {3'd0, 5'd9, 3'd0, 5'd1, 2'b11, 2'b00, 1'b1, 11'd0});
        host_read(2'd1, v); chk(v[7], "R5 op3 ready", v[7], 1);
        repeat (40) @(negedge clk);
        chk(rises == r0, "R5 no mdc", rises, r0);
        host_read(2'd3, v); chk(v == 32'hFFFF, "R5 rdata kept", v, 32'hFFFF);

        // R2: initiate bit clear
        host_write(2'd1, {3'd0, 5'd9, 3'd0, 5'd1, 2'b01, 2'b00, 1'b0, 11'd0});
        repeat (40) @(negedge clk);
        chk(rises == r0, "R2 no initiate no mdc", rises, r0);

        // R8: divider 3
        host_write(2'd0, 32'h43);
        host_read(2'd0, v); chk(v == 32'h43, "R1 cfg div3", v, 32'h43);
        launch(2'b01, 5'd31, 5'd31, 16'h8001);
        wait_ready();
        chk(period == 6, "R8 div3 period", period, 6);
        chk(frames == 5, "R3 frame count", frames, 5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule